// File: doc/BRIEF.md
# I/O Page Table Translation Engine

This block turns a DMA request, given as a virtual start address, a byte length and a direction, into a series of physical chunk descriptors. For every 4 KB page the request touches, it computes where that page's entry sits in a single-level table in memory. It reads the 32-bit entry through a memory read port and checks the entry's permission bits. If the page may be accessed, it presents one chunk carrying a 36-bit physical address and a length. A chunk never crosses a page boundary. Moving the data is left to whatever consumes the chunks.

The table base and the size of the translated window come in as plain configuration inputs from a register block. The window is 16 MB shifted left by the range code, and it ends at the top of the 32-bit space. Only the virtual-address bits below the window size index the table.

A page whose entry is not valid, or a write to a page whose entry is not writable, is a fault. The engine then stops the transfer at that page and loads a fixed status word and the page-aligned virtual address into the fault registers. It also raises an interrupt, which stays high until the register block pulses a clear. Each request finishes with a one-cycle done pulse and an error flag.

The request, memory-read and chunk interfaces are valid/ready. A sender holds valid and its payload steady until ready is seen at a clock edge, and the receiver may hold ready low for any number of cycles. Back-pressure on the chunk output stalls the engine without losing or repeating a chunk. The memory response is a one-cycle valid pulse with no ready, because at most one read is outstanding.

Top module: `iopt_xlate_engine`

## Requirements
- R1: `req_ready` is high only when the engine is idle and no memory read or chunk is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A request of length 0 produces no memory read and no chunk, and completes with `done_err` = 0.
- R2: The entry address on `mem_rd_addr` is (`cfg_base` << 4) + ((VA & (2^(24+`cfg_range`) − 1)) >> 10, with bits 1:0 cleared). VA is the start address of the current page, and `cfg_range` is a 3-bit code. The result is 36 bits wide and always a multiple of 4.
- R3: `mem_rd_valid` stays high with `mem_rd_addr` unchanged until `mem_rd_ready` is seen. Only one read is outstanding at a time. The entry is taken from `mem_rsp_data` in the cycle `mem_rsp_valid` is high, and the byte at the lowest memory address sits in bits 31:24.
- R4: Entry layout: bits 31:8 give physical page bits 35:12, bit 2 grants write, and bit 1 marks the entry valid. Bit 7 (cacheable) and the remaining bits have no effect. `chunk_paddr` is {entry[31:8], VA[11:0]}.
- R5: Chunks never cross a 4 KB boundary. The first chunk runs from the start address to the end of its page or to the end of the request, whichever comes first, and every later chunk starts on a page boundary. The lengths add up to `req_len`, and `chunk_last` marks the final chunk.
- R6: `chunk_valid` stays high with `chunk_paddr`, `chunk_len` and `chunk_last` unchanged until `chunk_ready` is seen at a clock edge.
- R7: A page whose entry has bit 1 clear, or a write (`req_write` = 1) to a page whose entry has bit 2 clear, is a fault. No chunk is produced for that page, the rest of the request is dropped, and `done_err` is 1.
- R8: On a fault, `flt_status` becomes 0xC0820000. Bit 18 is also set when the request is a read. `flt_addr` becomes the virtual address of the faulting page with bits 11:0 zero.
- R9: `irq` goes high on the edge that records a fault. It stays high until an edge where `irq_clear` is high and no new fault is being recorded.
- R10: After reset, `flt_status` = 0x00800000, `flt_addr` = 0, `irq` = 0 and `req_ready` = 1, and no valid output is high.
- R11: Each accepted request ends with `done_valid` high for exactly one cycle. This comes after the final chunk is accepted or after a fault is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Table base, shifted left by 4 to form a byte address |
| cfg_range | input | 3 | Window size code: 16 MB << code |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, request may be taken |
| req_vaddr | input | 32 | Virtual start address |
| req_len | input | 16 | Length in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid (one cycle) |
| mem_rsp_data | input | 32 | Entry word, lowest-address byte in 31:24 |
| chunk_valid | output | 1 | Chunk descriptor valid |
| chunk_ready | input | 1 | Consumer accepts the chunk |
| chunk_paddr | output | 36 | Physical start address |
| chunk_len | output | 13 | Chunk length in bytes (1 to 4096) |
| chunk_last | output | 1 | Final chunk of the request |
| done_valid | output | 1 | Request finished (one-cycle pulse) |
| done_err | output | 1 | Request ended on a fault |
| irq_clear | input | 1 | Lowers the interrupt |
| irq | output | 1 | Fault interrupt |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Page-aligned faulting virtual address |

## Verification
A wrong page cursor or remaining-length count shows up in the next `mem_rd_addr` after a chunk is accepted. It also appears as a chunk whose length breaks the page boundary or the running sum, so it is caught within a few cycles of the chunk that moved it. A mistaken permission decision shows up within one cycle of the entry's arrival, either as a chunk that should not exist or as a `done_err` and a status word that should not. The bench drives random stalls on both ready inputs and random response latency, so state that is lost under back-pressure appears as a payload that changes while valid is high.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int PTE_W      = 32;
  localparam int PPN_LSB    = 8;
  localparam int PA_W       = (PTE_W - PPN_LSB) + PAGE_SHIFT;
  localparam int CHUNK_W    = PAGE_SHIFT + 1;

  localparam int PTE_BIT_VALID = 1;
  localparam int PTE_BIT_WRITE = 2;

  localparam logic [31:0] FLT_STATUS_RESET = 32'h0080_0000;
  localparam logic [31:0] FLT_STATUS_BASE  = 32'hC082_0000;
  localparam int          FLT_BIT_READ     = 18;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_CHECK,
    ST_EMIT,
    ST_FAULT,
    ST_FIN
  } xl_state_e;
endpackage

// File: rtl/iopt_entry_addr.sv
module iopt_entry_addr #(
  parameter int VA_W          = 32,
  parameter int BASE_W        = 32,
  parameter int ADDR_W        = 36,
  parameter int PAGE_SHIFT    = 12,
  parameter int MIN_WIN_SHIFT = 24,
  parameter int RANGE_W       = 3
) (
  input  logic [BASE_W-1:0]  base,
  input  logic [RANGE_W-1:0] range_code,
  input  logic [VA_W-1:0]    page_va,
  output logic [ADDR_W-1:0]  entry_addr
);
  localparam int IDX_SHIFT = PAGE_SHIFT - 2;

  logic [VA_W-1:0]   win_mask;
  logic [VA_W-1:0]   win_off;
  logic [VA_W-1:0]   idx_bytes;
  logic [ADDR_W-1:0] base_bytes;

  always_comb begin
    win_mask   = (VA_W'(1) << (MIN_WIN_SHIFT + int'(range_code))) - VA_W'(1);
    win_off    = page_va & win_mask;
    idx_bytes  = win_off >> IDX_SHIFT;
    idx_bytes[1:0] = 2'b00;
    base_bytes = ADDR_W'(base) << 4;
    entry_addr = base_bytes + ADDR_W'(idx_bytes);
  end
endmodule

// File: rtl/iopt_chunk_calc.sv
module iopt_chunk_calc #(
  parameter int VA_W       = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [VA_W-1:0]       cur_va,
  input  logic [LEN_W-1:0]      remaining,
  output logic [PAGE_SHIFT:0]   piece_len,
  output logic                  piece_last
);
  localparam int CW = (LEN_W > PAGE_SHIFT + 1) ? LEN_W : PAGE_SHIFT + 1;
  localparam logic [PAGE_SHIFT:0] PAGE_BYTES = (PAGE_SHIFT + 1)'(1) << PAGE_SHIFT;

  logic [PAGE_SHIFT:0] room;
  logic [CW-1:0]       room_x;
  logic [CW-1:0]       rem_x;

  always_comb begin
    room       = PAGE_BYTES - {1'b0, cur_va[PAGE_SHIFT-1:0]};
    room_x     = CW'(room);
    rem_x      = CW'(remaining);
    piece_last = (rem_x <= room_x);
    piece_len  = piece_last ? (PAGE_SHIFT + 1)'(remaining) : room;
  end
endmodule

// File: rtl/iopt_fault_log.sv
module iopt_fault_log #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_fire,
  input  logic            fault_is_read,
  input  logic [VA_W-1:0] fault_va,
  input  logic            irq_clear,
  output logic [31:0]     status,
  output logic [VA_W-1:0] fault_addr,
  output logic            irq
);
  import iopt_pkg::*;

  logic [31:0] status_word;

  always_comb begin
    status_word = FLT_STATUS_BASE;
    status_word[FLT_BIT_READ] = fault_is_read;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status     <= FLT_STATUS_RESET;
      fault_addr <= '0;
      irq        <= 1'b0;
    end else if (fault_fire) begin
      status     <= status_word;
      fault_addr <= {fault_va[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      irq        <= 1'b1;
    end else if (irq_clear) begin
      irq        <= 1'b0;
    end
  end
endmodule

// File: rtl/iopt_xlate_engine.sv
module iopt_xlate_engine #(
  parameter int LEN_W     = 16,
  parameter int BASE_W    = 32,
  parameter int RANGE_W   = 3,
  parameter int WIN_SHIFT = 24
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [BASE_W-1:0]              cfg_base,
  input  logic [RANGE_W-1:0]             cfg_range,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [iopt_pkg::VA_W-1:0]      req_vaddr,
  input  logic [LEN_W-1:0]               req_len,
  input  logic                           req_write,
  output logic                           mem_rd_valid,
  input  logic                           mem_rd_ready,
  output logic [iopt_pkg::PA_W-1:0]      mem_rd_addr,
  input  logic                           mem_rsp_valid,
  input  logic [iopt_pkg::PTE_W-1:0]     mem_rsp_data,
  output logic                           chunk_valid,
  input  logic                           chunk_ready,
  output logic [iopt_pkg::PA_W-1:0]      chunk_paddr,
  output logic [iopt_pkg::CHUNK_W-1:0]   chunk_len,
  output logic                           chunk_last,
  output logic                           done_valid,
  output logic                           done_err,
  input  logic                           irq_clear,
  output logic                           irq,
  output logic [31:0]                    flt_status,
  output logic [iopt_pkg::VA_W-1:0]      flt_addr
);
  import iopt_pkg::*;

  xl_state_e            state;
  logic [VA_W-1:0]      cur_va;
  logic [LEN_W-1:0]     rem_len;
  logic                 is_wr;
  logic [PTE_W-1:0]     pte_q;
  logic                 err_q;
  logic [CHUNK_W-1:0]   piece_len;
  logic                 piece_last;
  logic                 pte_bad;

  iopt_entry_addr #(
    .VA_W(VA_W), .BASE_W(BASE_W), .ADDR_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT),
    .MIN_WIN_SHIFT(WIN_SHIFT), .RANGE_W(RANGE_W)
  ) u_eaddr (
    .base(cfg_base), .range_code(cfg_range),
    .page_va({cur_va[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}}),
    .entry_addr(mem_rd_addr)
  );

  iopt_chunk_calc #(
    .VA_W(VA_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_chunk (
    .cur_va(cur_va), .remaining(rem_len),
    .piece_len(piece_len), .piece_last(piece_last)
  );

  iopt_fault_log #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_flog (
    .clk(clk), .rst_n(rst_n),
    .fault_fire(state == ST_FAULT), .fault_is_read(!is_wr), .fault_va(cur_va),
    .irq_clear(irq_clear),
    .status(flt_status), .fault_addr(flt_addr), .irq(irq)
  );

  always_comb begin
    pte_bad      = !pte_q[PTE_BIT_VALID] || (is_wr && !pte_q[PTE_BIT_WRITE]);
    req_ready    = (state == ST_IDLE);
    mem_rd_valid = (state == ST_FETCH);
    chunk_valid  = (state == ST_EMIT);
    chunk_paddr  = {pte_q[PTE_W-1:PPN_LSB], cur_va[PAGE_SHIFT-1:0]};
    chunk_len    = piece_len;
    chunk_last   = piece_last;
    done_valid   = (state == ST_FIN);
    done_err     = err_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_va  <= '0;
      rem_len <= '0;
      is_wr   <= 1'b0;
      pte_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          cur_va  <= req_vaddr;
          rem_len <= req_len;
          is_wr   <= req_write;
          err_q   <= 1'b0;
          state   <= (req_len == '0) ? ST_FIN : ST_FETCH;
        end
        ST_FETCH: if (mem_rd_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          pte_q <= mem_rsp_data;
          state <= ST_CHECK;
        end
        ST_CHECK: state <= pte_bad ? ST_FAULT : ST_EMIT;
        ST_EMIT: if (chunk_ready) begin
          cur_va  <= cur_va + VA_W'(piece_len);
          rem_len <= rem_len - LEN_W'(piece_len);
          state   <= piece_last ? ST_FIN : ST_FETCH;
        end
        ST_FAULT: begin
          err_q <= 1'b1;
          state <= ST_FIN;
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iopt_xlate_checker.sv
module iopt_xlate_checker #(
  parameter int PA_W    = 36,
  parameter int CHUNK_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [PA_W-1:0]   mem_rd_addr,
  input logic              chunk_valid,
  input logic              chunk_ready,
  input logic [PA_W-1:0]   chunk_paddr,
  input logic [CHUNK_W-1:0] chunk_len,
  input logic              chunk_last,
  input logic              done_valid,
  input logic              done_err,
  input logic              irq,
  input logic              irq_clear,
  input logic [31:0]       flt_status,
  input logic [31:0]       flt_addr
);
  localparam int PS = CHUNK_W - 1;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid && !chunk_valid) else $error("idle busy"); // R1

  AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00) else $error("entry align"); // R2

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)) else $error("rd hold"); // R3

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (chunk_len != '0) &&
      ({1'b0, chunk_paddr[PS-1:0]} + chunk_len <= (CHUNK_W + 1)'(1 << PS))) else $error("cross"); // R5

  AST_CHUNK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_paddr) &&
      $stable(chunk_len) && $stable(chunk_last)) else $error("chunk hold"); // R6

  AST_FLT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> flt_status[31:16] == 16'hC082 || flt_status[31:16] == 16'hC086) else $error("status"); // R8

  AST_FLT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> flt_addr[PS-1:0] == '0) else $error("flt addr"); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clear |=> irq) else $error("irq sticky"); // R9

  AST_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_err |-> irq) else $error("err irq"); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid) else $error("done pulse"); // R11
endmodule

bind iopt_xlate_engine iopt_xlate_checker #(
  .PA_W(iopt_pkg::PA_W), .CHUNK_W(iopt_pkg::CHUNK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .chunk_valid(chunk_valid), .chunk_ready(chunk_ready), .chunk_paddr(chunk_paddr),
  .chunk_len(chunk_len), .chunk_last(chunk_last),
  .done_valid(done_valid), .done_err(done_err), .irq(irq), .irq_clear(irq_clear),
  .flt_status(flt_status), .flt_addr(flt_addr)
);

// File: tb/sim_iopt_xlate_engine.sv
module sim_iopt_xlate_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [2:0]  cfg_range = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [15:0] req_len = '0;
  logic        req_write = 1'b0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [35:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        chunk_valid;
  logic        chunk_ready = 1'b0;
  logic [35:0] chunk_paddr;
  logic [12:0] chunk_len;
  logic        chunk_last;
  logic        done_valid;
  logic        done_err;
  logic        irq_clear = 1'b0;
  logic        irq;
  logic [31:0] flt_status;
  logic [31:0] flt_addr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit          ovr_en = 1'b0;
  logic [31:0] ovr_pte = '0;

  iopt_xlate_engine u0 (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_entry(input logic [31:0] va, input logic [31:0] base,
                                            input logic [2:0] rng);
    logic [31:0] off;
    off = va & ((32'h1 << (24 + rng)) - 32'h1);
    off = (off >> 10) & ~32'h3;
    return ({4'h0, base} << 4) + {4'h0, off};
  endfunction

  function automatic logic [31:0] pte_fn(input logic [35:0] ea);
    logic [31:0] p;
    p = {ea[29:6] ^ 24'h5A5A5, 8'h00};
    p[1] = (ea[4:2] != 3'd5);
    p[2] = (ea[5:3] != 3'd2);
    p[7] = ea[6];
    p[0] = ea[7];
    return p;
  endfunction

  task automatic run_xfer(input logic [31:0] va, input logic [15:0] len, input bit wr);
    logic [31:0] cur;
    int          rem;
    bit          faulted;
    logic [31:0] pte;
    logic [35:0] ea;
    int          n;
    int          room;
    int          elen;
    cur = va; rem = len; faulted = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_vaddr = va; req_len = len; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
    while (rem > 0) begin
      n = 0;
      while (!mem_rd_valid && n < 20) begin
        chk(!chunk_valid && !done_valid, "R5", "output before read", chunk_valid, 0);
        @(negedge clk); n++;
      end
      ea = exp_entry({cur[31:12], 12'h0}, cfg_base, cfg_range);
      chk(mem_rd_valid, "R3", "read issued", mem_rd_valid, 1);
      chk(mem_rd_addr == ea, "R2", "entry address", mem_rd_addr, ea);
      for (int k = $urandom_range(0, 2); k > 0; k--) begin
        @(negedge clk);
        chk(mem_rd_valid && mem_rd_addr == ea, "R3", "read held", mem_rd_addr, ea);
      end
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      chk(!mem_rd_valid, "R3", "one read outstanding", mem_rd_valid, 0);
      for (int k = $urandom_range(0, 2); k > 0; k--) @(negedge clk);
      pte = ovr_en ? ovr_pte : pte_fn(ea);
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
      if (!pte[1] || (wr && !pte[2])) begin
        faulted = 1;
        n = 0;
        while (!done_valid && n < 20) begin
          chk(!chunk_valid, "R7", "no chunk on fault", chunk_valid, 0);
          @(negedge clk); n++;
        end
        chk(done_valid && done_err, "R7", "fault done_err", {done_valid, done_err}, 2'b11);
        chk(flt_status == (32'hC082_0000 | (wr ? 32'h0 : 32'h0004_0000)), "R8", "status",
            flt_status, 32'hC082_0000 | (wr ? 32'h0 : 32'h0004_0000));
        chk(flt_addr == {cur[31:12], 12'h0}, "R8", "fault address", flt_addr, {cur[31:12], 12'h0});
        chk(irq, "R9", "irq raised", irq, 1);
        break;
      end
      n = 0;
      while (!chunk_valid && n < 20) begin @(negedge clk); n++; end
      room = 4096 - cur[11:0];
      elen = (rem < room) ? rem : room;
      chk(chunk_valid, "R5", "chunk present", chunk_valid, 1);
      chk(chunk_paddr == {pte[31:8], cur[11:0]}, "R4", "physical address", chunk_paddr,
          {pte[31:8], cur[11:0]});
      chk(chunk_len == 13'(elen), "R5", "chunk length", chunk_len, elen);
      chk(chunk_last == (rem == elen), "R5", "last flag", chunk_last, rem == elen);
      for (int k = $urandom_range(0, 2); k > 0; k--) begin
        @(negedge clk);
        chk(chunk_valid && chunk_len == 13'(elen) && chunk_paddr == {pte[31:8], cur[11:0]},
            "R6", "chunk held", chunk_len, elen);
      end
      chunk_ready = 1'b1;
      @(negedge clk);
      chunk_ready = 1'b0;
      cur = cur + elen; rem = rem - elen;
    end
    if (!faulted) begin
      n = 0;
      while (!done_valid && n < 20) begin
        chk(!chunk_valid && !mem_rd_valid, "R5", "no extra output", chunk_valid, 0);
        @(negedge clk); n++;
      end
      chk(done_valid && !done_err, "R11", "clean done", {done_valid, done_err}, 2'b10);
    end
    @(negedge clk);
    chk(!done_valid, "R11", "done one cycle", done_valid, 0);
  endtask

  task automatic clear_irq();
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    chk(!irq, "R9", "irq cleared", irq, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(flt_status == 32'h0080_0000, "R10", "reset status", flt_status, 32'h0080_0000);
    chk(flt_addr == 0 && !irq, "R10", "reset addr/irq", {flt_addr, irq}, 0);
    chk(!mem_rd_valid && !chunk_valid && !done_valid, "R10", "reset valids", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R10", "ready after reset", req_ready, 1);

    cfg_base = 32'h0012_3400; cfg_range = 3'd2;
    run_xfer(32'hFC00_1000, 16'd0, 1'b0);        // R1 zero length
    ovr_en = 1; ovr_pte = 32'hABCD_EF86;           // R4: cacheable set, writable, valid
    run_xfer(32'hFC00_2000, 16'd4096, 1'b1);     // one full aligned page
    run_xfer(32'hFC00_2FFF, 16'd2, 1'b0);        // R5 two one-byte chunks
    ovr_pte = 32'h1111_1100;                       // R7 invalid entry, read
    run_xfer(32'hFC34_5678, 16'd100, 1'b0);
    repeat (3) @(negedge clk);
    chk(irq, "R9", "irq stays", irq, 1);
    clear_irq();
    ovr_pte = 32'h2222_2282;                       // R7 read-only entry, write
    run_xfer(32'hFC00_0F00, 16'd600, 1'b1);
    clear_irq();
    ovr_pte = 32'h3333_3302;                       // read-only entry, read allowed
    run_xfer(32'h8765_4321, 16'd5000, 1'b0);
    cfg_range = 3'd7;
    ovr_en = 0;
    run_xfer(32'hF7FF_F800, 16'd3000, 1'b0);     // R2 widest window
    cfg_range = 3'd0;
    run_xfer(32'h12FF_E010, 16'd2000, 1'b0);     // R2 upper bits ignored in narrow window

    for (int t = 0; t < 60; t++) begin
      cfg_base  = $urandom() & 32'h07FF_FC00;
      cfg_range = 3'($urandom_range(0, 7));
      run_xfer($urandom(), 16'($urandom_range(0, 9000)), 1'($urandom_range(0, 1)));
      if (irq) clear_irq();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule